// File: doc/BRIEF.md
# Serial Transceiver with LIN Break Generation and Detection

This block is an asynchronous serial transmitter and receiver that also handles the long dominant pulse that starts a LIN frame. A master node uses the transmit side to send either an ordinary character or a break of selectable length. A slave node uses the receive side to pick such a break out of the line even when its own clock differs from the master's by up to 15 percent. Characters carry 8 or 9 data bits, chosen by a character-length input. The data bits go out least significant bit first, framed by a low start bit and a high stop bit.

One divide counter produces an oversample tick every N system clocks, and every bit lasts 16 ticks. The receiver takes a majority vote of samples 7, 8 and 9 of each bit and counts consecutive low bits. In LIN mode it reports a break once that count reaches a threshold. A data character of 0x00 lasts at most 10.35 bit times and a master break lasts at least 11.05, so the threshold falls between them. After a break the receiver drops the pending character and waits for the line to return high.

Top module: `lin_uart`

## Requirements
- R1: After reset, txd is high, tx_ready is high, and rx_valid and brk_det are low.
- R2: A divisor N on cfg_div gives one oversample tick every N clocks, with 0 treated as 1. A bit lasts 16 ticks, so 16·N clocks.
- R3: A character request (tx_brk=0) sends a low start bit, then the data least significant bit first, then a high stop bit. cfg_long_char=0 sends 8 data bits (tx_data[7:0]) and cfg_long_char=1 sends 9 (tx_data[8:0]).
- R4: With cfg_tx_lin=0, a break request (tx_brk=1) drives txd low for 10 bit times when cfg_long_char=0 and for 11 when cfg_long_char=1.
- R5: With cfg_tx_lin=1, a break request drives txd low for 13 bit times when cfg_long_char=0 and for 14 when cfg_long_char=1.
- R6: After a break, txd stays high for exactly one bit time before tx_ready returns, so the next character cannot start inside that delimiter.
- R7: A well-formed character on rxd raises rx_valid for one cycle with the data on rx_data. With cfg_long_char=0, rx_data[8] reads 0.
- R8: A low pulse on rxd shorter than half a bit is rejected as a false start: no rx_valid and no brk_det follow.
- R9: With cfg_rx_lin=1 and cfg_long_char=0, brk_det pulses only after 11 consecutive low bit times. A 0x00 character (9 low bits) is still received, and a run of 10 low bits is dropped without a pulse.
- R10: With cfg_rx_lin=1 and cfg_long_char=1, the detect threshold is 12 consecutive low bit times. A run of 11 low bits gives no brk_det.
- R11: With cfg_rx_lin=0, an all-zero character whose stop bit is low raises brk_det. A non-zero character with a low stop bit is dropped without rx_valid or brk_det.
- R12: brk_det lasts one cycle and never coincides with rx_valid. A low run of any length gives exactly one pulse, and the receiver accepts no new start bit until rxd has been high.
- R13: tx_ready is high only while the transmitter is idle. A request is taken on a cycle with tx_valid and tx_ready both high, and the start bit or break begins on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tx_lin | input | 1 | Selects the long LIN break for transmit |
| cfg_rx_lin | input | 1 | Enables LIN break detection by low-run counting |
| cfg_long_char | input | 1 | 0: 8 data bits, 1: 9 data bits |
| cfg_div | input | DIV_W | Clocks per oversample tick (0 acts as 1) |
| tx_valid | input | 1 | Transmit request |
| tx_brk | input | 1 | The request is a break instead of a character |
| tx_data | input | 9 | Character to send |
| tx_ready | output | 1 | Transmitter idle and able to take a request |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, idle high |
| rx_data | output | 9 | Last received character |
| rx_valid | output | 1 | One-cycle pulse when rx_data is new |
| brk_det | output | 1 | One-cycle pulse when a break is recognised |

## Verification
The start bit or break appears on txd one cycle after the accepting edge, and each bit then lasts 16·N clocks. The bench samples each transmitted bit at its middle cycle, counts the exact run of low cycles, and counts the high cycles of the delimiter. On the receive side a falling edge on rxd passes two synchroniser stages and is taken on the third edge. A result for bit index b is decided 16·b+9 ticks later and shows on the next cycle. The bench therefore leaves at least three bit times of idle line after each stimulus before it compares the rx_valid and brk_det pulse counts and the captured rx_data. It counts those pulses at falling clock edges, so no pulse is missed or counted twice.

// File: rtl/lin_uart_pkg.sv
package lin_uart_pkg;
    localparam int DATA_W = 9;
    localparam int CNT_W  = 4;

    typedef enum logic [1:0] {TX_IDLE, TX_FRAME, TX_BREAK, TX_DELIM} tx_state_e;
    typedef enum logic [1:0] {RX_IDLE, RX_FRAME, RX_BRKRUN, RX_WAITHI} rx_state_e;

    // bit times of low level sent for a break request
    function automatic logic [CNT_W-1:0] tx_break_bits(input logic lin, input logic long_char);
        if (lin) return long_char ? 4'd14 : 4'd13;
        return long_char ? 4'd11 : 4'd10;
    endfunction

    // consecutive low bit times that mark a break on the receive side
    function automatic logic [CNT_W-1:0] rx_break_bits(input logic lin, input logic long_char);
        if (lin) return long_char ? 4'd12 : 4'd11;
        return long_char ? 4'd11 : 4'd10;
    endfunction
endpackage

// File: rtl/lin_uart_baud.sv
module lin_uart_baud #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } baud_st_t;

    baud_st_t s_d, s_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim      = (div == '0) ? '0 : div - DIV_W'(1);
        tick     = (s_q.cnt >= lim);
        s_d.cnt  = tick ? '0 : s_q.cnt + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/lin_uart_tx.sv
module lin_uart_tx
    import lin_uart_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              lin,
    input  logic              long_char,
    input  logic              req_valid,
    input  logic              req_brk,
    input  logic [DATA_W-1:0] req_data,
    output logic              ready,
    output logic              txd
);
    localparam int OVS_W   = $clog2(OVS);
    localparam int FRAME_W = DATA_W + 2;

    typedef struct packed {
        tx_state_e          state;
        logic [OVS_W-1:0]   tcnt;
        logic [CNT_W-1:0]   bcnt;
        logic [CNT_W-1:0]   last;
        logic [FRAME_W-1:0] sh;
    } tx_st_t;

    localparam tx_st_t TX_RST = '{state: TX_IDLE, tcnt: '0, bcnt: '0, last: '0, sh: '1};

    tx_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.state == TX_IDLE) begin
            if (req_valid) begin
                s_d.tcnt = '0;
                s_d.bcnt = '0;
                if (req_brk) begin
                    s_d.state = TX_BREAK;
                    s_d.last  = tx_break_bits(lin, long_char) - 4'd1;
                end else begin
                    s_d.state = TX_FRAME;
                    s_d.last  = long_char ? 4'd10 : 4'd9;
                    s_d.sh    = long_char ? {1'b1, req_data, 1'b0}
                                          : {2'b11, req_data[7:0], 1'b0};
                end
            end
        end else if (tick) begin
            s_d.tcnt = s_q.tcnt + OVS_W'(1);
            if (s_q.tcnt == OVS_W'(OVS - 1)) begin
                s_d.tcnt = '0;
                s_d.bcnt = s_q.bcnt + 4'd1;
                s_d.sh   = {1'b1, s_q.sh[FRAME_W-1:1]};
                if (s_q.bcnt == s_q.last) begin
                    s_d.bcnt  = '0;
                    s_d.last  = '0;
                    s_d.state = (s_q.state == TX_BREAK) ? TX_DELIM : TX_IDLE;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= TX_RST;
        else        s_q <= s_d;
    end

    assign ready = (s_q.state == TX_IDLE);
    assign txd   = (s_q.state == TX_FRAME) ? s_q.sh[0] : (s_q.state != TX_BREAK);
endmodule

// File: rtl/lin_uart_rx.sv
module lin_uart_rx
    import lin_uart_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              lin,
    input  logic              long_char,
    input  logic              rxd,
    output logic [DATA_W-1:0] data,
    output logic              valid,
    output logic              brk
);
    localparam int OVS_W = $clog2(OVS);
    localparam int MID   = OVS / 2 + 1;

    typedef struct packed {
        logic [1:0]        sync;
        rx_state_e         state;
        logic [OVS_W-1:0]  tcnt;
        logic [CNT_W-1:0]  bidx;
        logic [CNT_W-1:0]  run;
        logic              s7;
        logic              s8;
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] data;
        logic              valid;
        logic              brk;
    } rx_st_t;

    localparam rx_st_t RX_RST = '{sync: 2'b11, state: RX_IDLE, tcnt: '0, bidx: '0,
                                  run: '0, s7: 1'b1, s8: 1'b1, sh: '0, data: '0,
                                  valid: 1'b0, brk: 1'b0};

    rx_st_t s_d, s_q;
    logic              rx_s;
    logic              maj;
    logic [CNT_W-1:0]  run_n;
    logic [CNT_W-1:0]  stop_idx;

    always_comb begin
        s_d       = s_q;
        s_d.sync  = {s_q.sync[0], rxd};
        s_d.valid = 1'b0;
        s_d.brk   = 1'b0;
        rx_s      = s_q.sync[1];
        maj       = (s_q.s7 & s_q.s8) | (s_q.s7 & rx_s) | (s_q.s8 & rx_s);
        run_n     = maj ? '0 : ((s_q.run == '1) ? s_q.run : s_q.run + 4'd1);
        stop_idx  = long_char ? 4'd10 : 4'd9;

        unique case (s_q.state)
            RX_IDLE: begin
                if (tick && !rx_s) begin
                    s_d.state = RX_FRAME;
                    s_d.tcnt  = OVS_W'(1);
                    s_d.bidx  = '0;
                    s_d.run   = '0;
                    s_d.sh    = '0;
                end
            end
            RX_WAITHI: begin
                if (rx_s) s_d.state = RX_IDLE;
            end
            default: begin
                if (tick) begin
                    s_d.tcnt = s_q.tcnt + OVS_W'(1);
                    if (s_q.tcnt == OVS_W'(OVS - 1)) begin
                        s_d.tcnt = '0;
                        s_d.bidx = s_q.bidx + 4'd1;
                    end
                    if (s_q.tcnt == OVS_W'(MID - 2)) s_d.s7 = rx_s;
                    if (s_q.tcnt == OVS_W'(MID - 1)) s_d.s8 = rx_s;
                    if (s_q.tcnt == OVS_W'(MID)) begin
                        s_d.run = run_n;
                        if (lin && !maj && run_n >= rx_break_bits(1'b1, long_char)) begin
                            s_d.brk   = 1'b1;
                            s_d.state = RX_WAITHI;
                        end else if (s_q.state == RX_BRKRUN) begin
                            if (maj) s_d.state = RX_IDLE;
                        end else if (s_q.bidx == '0) begin
                            if (maj) s_d.state = RX_IDLE;
                        end else if (s_q.bidx == stop_idx) begin
                            if (maj) begin
                                s_d.valid = 1'b1;
                                s_d.data  = long_char ? s_q.sh : {1'b0, s_q.sh[DATA_W-1:1]};
                                s_d.state = RX_IDLE;
                            end else if (lin) begin
                                s_d.state = RX_BRKRUN;
                            end else if (s_q.sh == '0) begin
                                s_d.brk   = 1'b1;
                                s_d.state = RX_WAITHI;
                            end else begin
                                s_d.state = RX_WAITHI;
                            end
                        end else begin
                            s_d.sh = {maj, s_q.sh[DATA_W-1:1]};
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RX_RST;
        else        s_q <= s_d;
    end

    assign data  = s_q.data;
    assign valid = s_q.valid;
    assign brk   = s_q.brk;
endmodule

// File: rtl/lin_uart.sv
module lin_uart
    import lin_uart_pkg::*;
#(
    parameter int DIV_W = 12,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_tx_lin,
    input  logic             cfg_rx_lin,
    input  logic             cfg_long_char,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             tx_valid,
    input  logic             tx_brk,
    input  logic [8:0]       tx_data,
    output logic             tx_ready,
    output logic             txd,
    input  logic             rxd,
    output logic [8:0]       rx_data,
    output logic             rx_valid,
    output logic             brk_det
);
    logic baud_tick;

    lin_uart_baud #(.DIV_W(DIV_W)) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .div  (cfg_div),
        .tick (baud_tick)
    );

    lin_uart_tx #(.OVS(OVS)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (baud_tick),
        .lin      (cfg_tx_lin),
        .long_char(cfg_long_char),
        .req_valid(tx_valid),
        .req_brk  (tx_brk),
        .req_data (tx_data),
        .ready    (tx_ready),
        .txd      (txd)
    );

    lin_uart_rx #(.OVS(OVS)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (baud_tick),
        .lin      (cfg_rx_lin),
        .long_char(cfg_long_char),
        .rxd      (rxd),
        .data     (rx_data),
        .valid    (rx_valid),
        .brk      (brk_det)
    );
endmodule

// File: rtl/lin_uart_chk.sv
module lin_uart_chk
    import lin_uart_pkg::*;
#(
    parameter int OVS = 16
) (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic cfg_rx_lin,
    input logic cfg_long_char,
    input logic tx_valid,
    input logic tx_ready,
    input logic txd,
    input logic rxd,
    input logic rx_valid,
    input logic brk_det
);
    logic [8:0] rx_low_q;
    logic [8:0] tx_low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_low_q <= '0;
            tx_low_q <= '0;
        end else begin
            if (rxd) rx_low_q <= '0;
            else if (tick && rx_low_q != '1) rx_low_q <= rx_low_q + 9'd1;
            if (txd) tx_low_q <= '0;
            else if (tick && tx_low_q != '1) tx_low_q <= tx_low_q + 9'd1;
        end
    end

    p_tx_start_r13: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready |=> !txd && !tx_ready);

    p_tx_low_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tx_low_q) <= OVS * 14);

    p_brk_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        brk_det |=> !brk_det);

    p_brk_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(brk_det && rx_valid));

    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R9, R10, R11: no break before the low run spans the threshold
    p_brk_min_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        brk_det |-> int'(rx_low_q) >= OVS * (int'(rx_break_bits(cfg_rx_lin, cfg_long_char)) - 1));
endmodule

bind lin_uart lin_uart_chk #(.OVS(OVS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (baud_tick),
    .cfg_rx_lin   (cfg_rx_lin),
    .cfg_long_char(cfg_long_char),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .txd          (txd),
    .rxd          (rxd),
    .rx_valid     (rx_valid),
    .brk_det      (brk_det)
);

// File: tb/tb_lin_uart.sv
`timescale 1ns/1ps
module tb_lin_uart;
    localparam int DIV_W = 12;
    localparam int BT    = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_tx_lin = 1'b0, cfg_rx_lin = 1'b0, cfg_long_char = 1'b0;
    logic [DIV_W-1:0] cfg_div = 12'd1;
    logic tx_valid = 1'b0, tx_brk = 1'b0;
    logic [8:0] tx_data = '0;
    logic tx_ready, txd;
    logic rx_drv = 1'b1, loopback = 1'b0;
    logic rxd;
    logic [8:0] rx_data;
    logic rx_valid, brk_det;

    assign rxd = loopback ? txd : rx_drv;

    always #5 clk = ~clk;

    lin_uart #(.DIV_W(DIV_W), .OVS(16)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_tx_lin(cfg_tx_lin), .cfg_rx_lin(cfg_rx_lin),
        .cfg_long_char(cfg_long_char), .cfg_div(cfg_div), .tx_valid(tx_valid),
        .tx_brk(tx_brk), .tx_data(tx_data), .tx_ready(tx_ready), .txd(txd),
        .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid), .brk_det(brk_det));

    int checks = 0, fails = 0;
    int brk_cnt = 0, val_cnt = 0;
    logic [8:0] last_rx = '0;
    bit done = 1'b0;
    int cyc = 0;

    always @(negedge clk) begin
        if (brk_det) brk_cnt++;
        if (rx_valid) begin
            val_cnt++;
            last_rx = rx_data;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Accept a request; returns at the falling edge just after the accepting edge
    task automatic tx_req(input logic brk, input logic [8:0] d);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_valid = 1'b1; tx_brk = brk; tx_data = d;
        @(negedge clk);
        tx_valid = 1'b0; tx_brk = 1'b0;
    endtask

    task automatic break_len(input logic lin, input logic m, input int exp_low, input string req);
        int lo, hi;
        cfg_tx_lin = lin; cfg_long_char = m;
        tx_req(1'b1, 9'h0);
        lo = 0;
        while (txd == 1'b0 && lo < 1000) begin lo++; @(negedge clk); end
        chk(lo == exp_low, req, "break low cycles", lo, exp_low);
        hi = 0;
        while (!tx_ready && hi < 1000) begin hi++; @(negedge clk); end
        chk(hi == BT, "R6", "delimiter cycles", hi, BT);
    endtask

    task automatic frame_capture(input logic m, input logic [8:0] d);
        logic [10:0] got;
        logic [10:0] exp;
        int nb;
        nb  = m ? 11 : 10;
        exp = m ? {1'b1, d, 1'b0} : {2'b11, d[7:0], 1'b0};
        got = '1;
        cfg_long_char = m;
        tx_req(1'b0, d);
        chk(tx_ready == 1'b0, "R13", "ready after accept", int'(tx_ready), 0);
        for (int k = 0; k < nb; k++) begin
            repeat ((k == 0) ? 8 : BT) @(negedge clk);
            got[k] = txd;
        end
        chk(got == exp, "R3", "frame bits", int'(got), int'(exp));
        repeat (BT) @(negedge clk);
        chk(tx_ready == 1'b1, "R13", "ready after frame", int'(tx_ready), 1);
    endtask

    task automatic rx_level(input logic v, input int nbits);
        rx_drv = v;
        repeat (nbits * BT) @(negedge clk);
    endtask

    typedef struct packed {
        logic       m;
        logic       lin;
        logic [4:0] low;
        logic       brk;
        logic       val;
        logic [3:0] req;
    } vec_t;

    localparam vec_t VEC [11] = '{
        '{1'b0, 1'b1, 5'd9,  1'b0, 1'b1, 4'd9},
        '{1'b0, 1'b1, 5'd10, 1'b0, 1'b0, 4'd9},
        '{1'b0, 1'b1, 5'd11, 1'b1, 1'b0, 4'd9},
        '{1'b0, 1'b1, 5'd13, 1'b1, 1'b0, 4'd9},
        '{1'b1, 1'b1, 5'd10, 1'b0, 1'b1, 4'd10},
        '{1'b1, 1'b1, 5'd11, 1'b0, 1'b0, 4'd10},
        '{1'b1, 1'b1, 5'd12, 1'b1, 1'b0, 4'd10},
        '{1'b0, 1'b0, 5'd9,  1'b0, 1'b1, 4'd11},
        '{1'b0, 1'b0, 5'd10, 1'b1, 1'b0, 4'd11},
        '{1'b1, 1'b0, 5'd11, 1'b1, 1'b0, 4'd11},
        '{1'b0, 1'b0, 5'd20, 1'b1, 1'b0, 4'd12}
    };

    function automatic string req_name(input logic [3:0] r);
        case (r)
            4'd9:    return "R9";
            4'd10:   return "R10";
            4'd11:   return "R11";
            default: return "R12";
        endcase
    endfunction

    initial begin
        int b0, v0;
        repeat (3) @(negedge clk);
        chk(txd == 1'b1, "R1", "txd in reset", int'(txd), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd == 1'b1 && tx_ready == 1'b1, "R1", "tx idle after reset", int'({txd, tx_ready}), 3);
        chk(rx_valid == 1'b0 && brk_det == 1'b0, "R1", "rx outputs after reset", int'({rx_valid, brk_det}), 0);
        repeat (4) @(negedge clk);

        // receive-side vector table
        for (int i = 0; i < 11; i++) begin
            cfg_long_char = VEC[i].m;
            cfg_rx_lin    = VEC[i].lin;
            b0 = brk_cnt; v0 = val_cnt;
            rx_level(1'b0, int'(VEC[i].low));
            rx_level(1'b1, 4);
            chk(brk_cnt - b0 == int'(VEC[i].brk), req_name(VEC[i].req), $sformatf("vec %0d brk pulses", i),
                brk_cnt - b0, int'(VEC[i].brk));
            chk(val_cnt - v0 == int'(VEC[i].val), req_name(VEC[i].req), $sformatf("vec %0d rx_valid pulses", i),
                val_cnt - v0, int'(VEC[i].val));
            if (VEC[i].val)
                chk(last_rx == 9'h000, req_name(VEC[i].req), "zero char data", int'(last_rx), 0);
        end
        cfg_rx_lin = 1'b0;

        // transmit framing
        frame_capture(1'b0, 9'h0A5);
        frame_capture(1'b1, 9'h1C3);

        // break lengths
        break_len(1'b0, 1'b0, 10 * BT, "R4");
        break_len(1'b0, 1'b1, 11 * BT, "R4");
        break_len(1'b1, 1'b0, 13 * BT, "R5");
        break_len(1'b1, 1'b1, 14 * BT, "R5");

        // divisor 2 doubles the bit time
        cfg_div = 12'd2; cfg_tx_lin = 1'b1; cfg_long_char = 1'b0;
        begin
            int lo;
            tx_req(1'b1, 9'h0);
            lo = 0;
            while (txd == 1'b0 && lo < 2000) begin lo++; @(negedge clk); end
            chk(lo >= 13 * BT * 2 - 2 && lo <= 13 * BT * 2 + 2, "R2", "break low at div 2", lo, 13 * BT * 2);
            while (!tx_ready) @(negedge clk);
        end
        cfg_div = 12'd0;
        begin
            int lo;
            cfg_tx_lin = 1'b0;
            tx_req(1'b1, 9'h0);
            lo = 0;
            while (txd == 1'b0 && lo < 2000) begin lo++; @(negedge clk); end
            chk(lo == 10 * BT, "R2", "divisor 0 acts as 1", lo, 10 * BT);
            while (!tx_ready) @(negedge clk);
        end
        cfg_div = 12'd1;

        // loopback reception
        loopback = 1'b1;
        cfg_long_char = 1'b0; cfg_rx_lin = 1'b0;
        v0 = val_cnt;
        tx_req(1'b0, 9'h1A5);
        repeat (12 * BT) @(negedge clk);
        chk(val_cnt - v0 == 1, "R7", "8-bit receive pulses", val_cnt - v0, 1);
        chk(last_rx == 9'h0A5, "R7", "8-bit receive data", int'(last_rx), 9'h0A5);
        cfg_long_char = 1'b1;
        v0 = val_cnt;
        tx_req(1'b0, 9'h15A);
        repeat (13 * BT) @(negedge clk);
        chk(val_cnt - v0 == 1 && last_rx == 9'h15A, "R7", "9-bit receive data", int'(last_rx), 9'h15A);

        // after a long break, the next character is still taken
        cfg_long_char = 1'b0; cfg_rx_lin = 1'b1; cfg_tx_lin = 1'b1;
        b0 = brk_cnt; v0 = val_cnt;
        tx_req(1'b1, 9'h0);
        tx_req(1'b0, 9'h03C);
        repeat (12 * BT) @(negedge clk);
        chk(brk_cnt - b0 == 1, "R12", "looped break pulses", brk_cnt - b0, 1);
        chk(val_cnt - v0 == 1 && last_rx == 9'h03C, "R12", "char after break", int'(last_rx), 9'h03C);
        loopback = 1'b0; cfg_rx_lin = 1'b0;

        // false start
        b0 = brk_cnt; v0 = val_cnt;
        rx_drv = 1'b0;
        repeat (5) @(negedge clk);
        rx_drv = 1'b1;
        repeat (14 * BT) @(negedge clk);
        chk(brk_cnt - b0 == 0 && val_cnt - v0 == 0, "R8", "short pulse rejected",
            (brk_cnt - b0) + (val_cnt - v0), 0);

        // non-zero character with low stop bit, normal mode: start, d0=1, rest 0, stop 0
        b0 = brk_cnt; v0 = val_cnt;
        rx_level(1'b0, 1);
        rx_level(1'b1, 1);
        rx_level(1'b0, 8);
        rx_level(1'b1, 4);
        chk(brk_cnt - b0 == 0 && val_cnt - v0 == 0, "R11", "non-zero framing error dropped",
            (brk_cnt - b0) + (val_cnt - v0), 0);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule